// File: doc/BRIEF.md
# PCM Serial Frame Decoder with Resynchronisation

This block turns a one-bit-per-strobe serial PCM stream back into parallel audio samples. Each frame is 64 bit slots: a 16-bit alignment word `1111111100000000`, a 16-bit left sample, one left parity bit, a 16-bit right sample, one right parity bit and a 14-bit subcode field. Bits are sent most significant first. A bit counts only in a cycle where `bit_en` is high, so the block can sit behind any line-rate clock enable.

From reset the decoder slides a 16-bit window over the stream, looking for the alignment word at every bit offset. A first hit only proposes an alignment. Lock is declared when a second alignment word sits exactly one frame later. While locked, the alignment slot is checked in every frame. The left and right samples go out together with one valid pulse, and each comes with a flag that is high when the sample fails odd parity. A single corrupted alignment word is tolerated. Two in a row, as a bit slip produces, drop lock and restart the search, so the receiver recovers by itself.

Top module: `pcm_frame_decoder`

## Requirements
- R1: After reset `locked`, `sample_valid`, both parity flags, `left_out`, `right_out` and `subcode_out` are all zero.
- R2: The sliding search finds the alignment word at any bit offset. `locked` rises one cycle after the bit strobe that carries the last bit of a second alignment word found exactly 64 bit slots after the first.
- R3: If the slot one frame after a first hit does not hold the alignment word, `locked` stays low and the search restarts. A later pair of correctly spaced words still acquires lock.
- R4: Frame slots, counting from 0 at the first alignment bit: left sample in slots 16..31, left parity in slot 32, right sample in slots 33..48, right parity in slot 49, subcode in slots 50..63. Every field is MSB first.
- R5: While locked, `sample_valid` is high for exactly one cycle per frame, namely the cycle after the strobe of slot 49. `left_out`, `right_out` and both parity flags change only in that cycle.
- R6: A parity flag is 1 when its 16 sample bits plus its parity bit hold an even number of ones, and 0 when they hold an odd number.
- R7: While locked, `subcode_out` takes the 14 subcode bits in the cycle after the strobe of slot 63.
- R8: While locked, one mismatched alignment word keeps lock and data flowing. A matching word clears the miss count. A second consecutive mismatch drops `locked` in the cycle after the strobe of slot 15.
- R9: While not locked, `sample_valid` never pulses.
- R10: Cycles with `bit_en` low change no state and no output, whatever `bit_in` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | High in a cycle that carries one stream bit |
| bit_in | input | 1 | Serial stream bit, sampled when `bit_en` is high |
| left_out | output | 16 | Last left sample |
| right_out | output | 16 | Last right sample |
| sample_valid | output | 1 | One-cycle pulse when a new sample pair is presented |
| left_perr | output | 1 | Left sample failed odd parity |
| right_perr | output | 1 | Right sample failed odd parity |
| subcode_out | output | 14 | Last subcode field |
| locked | output | 1 | Frame alignment is held |

## Verification
The bench keeps the default 16-bit samples, 14-bit subcode and a miss limit of two, so a frame is 64 slots and every acquisition offset from 0 to 63 is swept one by one. Search-phase payloads are masked so that no run of eight ones occurs outside the alignment word. This lets the bench predict exactly when lock is taken. Locked-phase payloads use full 16-bit values, including all-zero and all-one samples, with parity flips in each combination. Uneven idle gaps with a toggling `bit_in` run through the whole test. Miss counting, the verify failure and a one-bit slip are each driven to the cycle where `locked` is expected to change.

// File: rtl/pcm_dec_pkg.sv
// Package: types shared by the frame decoder modules.
// Assumes: nothing; holds only the alignment state encoding.
package pcm_dec_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } lock_state_t;

endpackage

// File: rtl/pcm_sync_window.sv
// Sliding window over the last SYNC_W stream bits; flags a match with
// the alignment word in the same cycle as the bit that completes it.
// Assumes: bits arrive MSB first, one per bit_en.
module pcm_sync_window #(
    parameter int                SYNC_W    = 16,
    parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hFF00
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic sync_hit
);

    logic [SYNC_W-1:0] win_q;
    logic [SYNC_W-1:0] win_next;

    // Window content once the current bit is shifted in.
    always_comb begin
        win_next = {win_q[SYNC_W-2:0], bit_in};
    end

    // Shift the window on every accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (bit_en) begin
            win_q <= win_next;
        end
    end

    // Match flag valid only in a bit cycle.
    always_comb begin
        sync_hit = bit_en && (win_next == SYNC_WORD);
    end

endmodule

// File: rtl/pcm_frame_counter.sv
// Bit slot counter within a frame. pos is the slot of the bit arriving
// in the current bit_en cycle; realign forces the next slot to ALIGN_POS.
// Assumes: realign is only asserted together with bit_en.
module pcm_frame_counter #(
    parameter int FRAME_LEN = 64,
    parameter int ALIGN_POS = 16,
    parameter int POS_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             realign,
    output logic [POS_W-1:0] pos
);

    localparam logic [POS_W-1:0] LAST_V  = POS_W'(FRAME_LEN - 1);
    localparam logic [POS_W-1:0] ALIGN_V = POS_W'(ALIGN_POS);

    logic [POS_W-1:0] pos_q;

    // Advance, wrap or realign the slot counter per accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (bit_en) begin
            if (realign) begin
                pos_q <= ALIGN_V;
            end else if (pos_q == LAST_V) begin
                pos_q <= '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    assign pos = pos_q;

endmodule

// File: rtl/pcm_lock_fsm.sv
// Alignment state machine: search with sliding compare, verify one frame
// later, then police the alignment slot each frame and drop lock after
// MISS_LIMIT consecutive mismatches.
// Assumes: pos is the slot of the current bit; SYNC_END is the last
// alignment slot.
module pcm_lock_fsm
    import pcm_dec_pkg::*;
#(
    parameter int POS_W      = 6,
    parameter int SYNC_END   = 15,
    parameter int MISS_LIMIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             sync_hit,
    input  logic [POS_W-1:0] pos,
    output lock_state_t      state,
    output logic             realign
);

    localparam int                MISS_W  = $clog2(MISS_LIMIT + 1);
    localparam logic [POS_W-1:0]  SYNC_V  = POS_W'(SYNC_END);
    localparam logic [MISS_W-1:0] LIMIT_M = MISS_W'(MISS_LIMIT - 1);

    lock_state_t       state_q;
    logic [MISS_W-1:0] miss_q;
    logic              at_sync;

    // Slot where an aligned frame must end its alignment word.
    always_comb begin
        at_sync = bit_en && (pos == SYNC_V);
        realign = bit_en && (state_q == ST_SEARCH) && sync_hit;
    end

    // State and miss counter transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SEARCH;
            miss_q  <= '0;
        end else begin
            case (state_q)
                ST_SEARCH: begin
                    miss_q <= '0;
                    if (realign) begin
                        state_q <= ST_VERIFY;
                    end
                end
                ST_VERIFY: begin
                    if (at_sync) begin
                        state_q <= sync_hit ? ST_LOCKED : ST_SEARCH;
                    end
                end
                ST_LOCKED: begin
                    if (at_sync) begin
                        if (sync_hit) begin
                            miss_q <= '0;
                        end else if (miss_q == LIMIT_M) begin
                            miss_q  <= '0;
                            state_q <= ST_SEARCH;
                        end else begin
                            miss_q <= miss_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_q <= ST_SEARCH;
                    miss_q  <= '0;
                end
            endcase
        end
    end

    assign state = state_q;

endmodule

// File: rtl/pcm_word_unpacker.sv
// Collects the payload fields by slot position, checks per-channel parity
// and presents the sample pair with a one-cycle strobe while locked.
// Assumes: fields are MSB first; each parity bit directly follows its sample.
module pcm_word_unpacker #(
    parameter int SAMPLE_W   = 16,
    parameter int SUB_W      = 14,
    parameter int POS_W      = 6,
    parameter int LP_POS     = 32,
    parameter int RP_POS     = 49,
    parameter int END_POS    = 63,
    parameter bit ODD_PARITY = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                bit_in,
    input  logic [POS_W-1:0]    pos,
    input  logic                locked,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                left_perr,
    output logic                right_perr,
    output logic                sample_valid,
    output logic [SUB_W-1:0]    subcode_out
);

    localparam int ACC_W = (SAMPLE_W + 1 > SUB_W) ? SAMPLE_W + 1 : SUB_W;
    localparam logic [POS_W-1:0] LP_V  = POS_W'(LP_POS);
    localparam logic [POS_W-1:0] RP_V  = POS_W'(RP_POS);
    localparam logic [POS_W-1:0] END_V = POS_W'(END_POS);

    logic [ACC_W-1:0]    acc_q;
    logic [ACC_W-1:0]    acc_next;
    logic                par_bad;
    logic [SAMPLE_W-1:0] left_hold;
    logic                lerr_hold;

    // Accumulator content including the current bit.
    always_comb begin
        acc_next = {acc_q[ACC_W-2:0], bit_in};
    end

    // Parity sense chosen by parameter.
    generate
        if (ODD_PARITY) begin : g_odd
            always_comb par_bad = ~(^acc_next[SAMPLE_W:0]);
        end else begin : g_even
            always_comb par_bad = ^acc_next[SAMPLE_W:0];
        end
    endgenerate

    // Shift every accepted bit into the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (bit_en) begin
            acc_q <= acc_next;
        end
    end

    // Park the left sample and its check until the pair is complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold <= '0;
            lerr_hold <= 1'b0;
        end else if (bit_en && pos == LP_V) begin
            left_hold <= acc_next[SAMPLE_W:1];
            lerr_hold <= par_bad;
        end
    end

    // Present the pair and flags with one strobe after the right parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_out     <= '0;
            right_out    <= '0;
            left_perr    <= 1'b0;
            right_perr   <= 1'b0;
            sample_valid <= 1'b0;
        end else begin
            sample_valid <= 1'b0;
            if (bit_en && locked && pos == RP_V) begin
                left_out     <= left_hold;
                left_perr    <= lerr_hold;
                right_out    <= acc_next[SAMPLE_W:1];
                right_perr   <= par_bad;
                sample_valid <= 1'b1;
            end
        end
    end

    // Capture the subcode at the last frame slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            subcode_out <= '0;
        end else if (bit_en && locked && pos == END_V) begin
            subcode_out <= acc_next[SUB_W-1:0];
        end
    end

endmodule

// File: rtl/pcm_frame_decoder.sv
// Top: serial PCM frame decoder. Finds frame alignment on a fixed
// alignment word, unpacks two parity-protected samples and a subcode
// field per frame, and reacquires alignment after slips.
// Assumes: one stream bit per bit_en cycle, MSB first.
module pcm_frame_decoder
    import pcm_dec_pkg::*;
#(
    parameter int                SYNC_W     = 16,
    parameter logic [SYNC_W-1:0] SYNC_WORD  = 16'hFF00,
    parameter int                SAMPLE_W   = 16,
    parameter int                SUB_W      = 14,
    parameter int                MISS_LIMIT = 2,
    parameter bit                ODD_PARITY = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                bit_in,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                sample_valid,
    output logic                left_perr,
    output logic                right_perr,
    output logic [SUB_W-1:0]    subcode_out,
    output logic                locked
);

    localparam int FRAME_LEN = SYNC_W + 2 * (SAMPLE_W + 1) + SUB_W;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam int SYNC_END  = SYNC_W - 1;
    localparam int LP_POS    = SYNC_W + SAMPLE_W;
    localparam int RP_POS    = LP_POS + SAMPLE_W + 1;
    localparam int END_POS   = FRAME_LEN - 1;

    logic             sync_hit;
    logic             realign;
    logic [POS_W-1:0] pos;
    lock_state_t      fsm_state;

    pcm_sync_window #(
        .SYNC_W    (SYNC_W),
        .SYNC_WORD (SYNC_WORD)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .sync_hit (sync_hit)
    );

    pcm_frame_counter #(
        .FRAME_LEN (FRAME_LEN),
        .ALIGN_POS (SYNC_W),
        .POS_W     (POS_W)
    ) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .realign (realign),
        .pos     (pos)
    );

    pcm_lock_fsm #(
        .POS_W      (POS_W),
        .SYNC_END   (SYNC_END),
        .MISS_LIMIT (MISS_LIMIT)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .sync_hit (sync_hit),
        .pos      (pos),
        .state    (fsm_state),
        .realign  (realign)
    );

    // Lock indicator straight from the state register.
    assign locked = (fsm_state == ST_LOCKED);

    pcm_word_unpacker #(
        .SAMPLE_W   (SAMPLE_W),
        .SUB_W      (SUB_W),
        .POS_W      (POS_W),
        .LP_POS     (LP_POS),
        .RP_POS     (RP_POS),
        .END_POS    (END_POS),
        .ODD_PARITY (ODD_PARITY)
    ) u_unpack (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .bit_in       (bit_in),
        .pos          (pos),
        .locked       (locked),
        .left_out     (left_out),
        .right_out    (right_out),
        .left_perr    (left_perr),
        .right_perr   (right_perr),
        .sample_valid (sample_valid),
        .subcode_out  (subcode_out)
    );

endmodule

// File: rtl/pcm_frame_decoder_chk.sv
// Checker for the frame decoder: temporal properties on its ports and
// lock state. Attached to every decoder instance by the bind below.
module pcm_frame_decoder_chk
    import pcm_dec_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int SUB_W    = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bit_en,
    input logic                sample_valid,
    input logic                locked,
    input logic [SAMPLE_W-1:0] left_out,
    input logic [SAMPLE_W-1:0] right_out,
    input logic                left_perr,
    input logic                right_perr,
    input logic [SUB_W-1:0]    subcode_out,
    input lock_state_t         fsm_state
);

    // R5
    valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R5
    pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> $stable({left_out, right_out, left_perr, right_perr}));

    // R9
    valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> locked);

    // R2
    lock_after_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(fsm_state) == ST_VERIFY));

    // R10
    idle_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(locked));

    // R10
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> !sample_valid);

    // R7
    idle_subcode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(subcode_out));

endmodule

bind pcm_frame_decoder pcm_frame_decoder_chk #(
    .SAMPLE_W (SAMPLE_W),
    .SUB_W    (SUB_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_en       (bit_en),
    .sample_valid (sample_valid),
    .locked       (locked),
    .left_out     (left_out),
    .right_out    (right_out),
    .left_perr    (left_perr),
    .right_perr   (right_perr),
    .subcode_out  (subcode_out),
    .fsm_state    (fsm_state)
);

// File: tb/tb_pcm_frame_decoder.sv
module tb_pcm_frame_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b0;
    logic [15:0] left_out;
    logic [15:0] right_out;
    logic        sample_valid;
    logic        left_perr;
    logic        right_perr;
    logic [13:0] subcode_out;
    logic        locked;

    int checks = 0;
    int fails = 0;
    int vpulses = 0;
    int gapk = 0;
    bit done = 0;

    localparam logic [15:0] SYNC_OK  = 16'hFF00;
    localparam logic [15:0] SYNC_BAD = 16'hFF01;

    pcm_frame_decoder dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .bit_in       (bit_in),
        .left_out     (left_out),
        .right_out    (right_out),
        .sample_valid (sample_valid),
        .left_perr    (left_perr),
        .right_perr   (right_perr),
        .subcode_out  (subcode_out),
        .locked       (locked)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // R9: count strobes and check none appears without lock
    always @(negedge clk) begin
        if (rst_n && sample_valid) begin
            vpulses++;
            chk(locked, "R9", {31'd0, locked}, 32'd1);
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_bit(input logic b);
        bit_en = 1'b1;
        bit_in = b;
        @(negedge clk);
        bit_en = 1'b0;
        bit_in = ~b;
    endtask

    task automatic idle(input int n);
        for (int g = 0; g < n; g++) begin
            bit_in = ~bit_in;
            @(negedge clk);
        end
    endtask

    // mode: 0 no strobe expected, 1 strobe with values, 2 don't care
    // lk15: expected locked after slot 15, 2 = don't care
    task automatic send_frame(input logic [15:0] sw, input logic [15:0] l, input logic [15:0] r,
                              input logic [13:0] sc, input bit fl, input bit fr,
                              input int mode, input int lk15, input int len);
        logic [63:0] fb;
        int v0;
        fb = {sw, l, ~(^l) ^ fl, r, ~(^r) ^ fr, sc};
        v0 = vpulses;
        for (int i = 0; i < len; i++) begin
            send_bit(fb[63-i]);
            if (i == 15 && lk15 != 2)
                chk(locked == lk15[0], "R2/R3/R8 lock at slot 15", {31'd0, locked}, lk15);
            if (i == 49 && mode == 1) begin
                chk(sample_valid, "R5 strobe", {31'd0, sample_valid}, 32'd1);
                chk(left_out == l, "R4 left", {16'd0, left_out}, {16'd0, l});
                chk(right_out == r, "R4 right", {16'd0, right_out}, {16'd0, r});
                chk(left_perr == fl, "R6 left parity", {31'd0, left_perr}, {31'd0, fl});
                chk(right_perr == fr, "R6 right parity", {31'd0, right_perr}, {31'd0, fr});
            end
            if (i == 49 && mode == 0)
                chk(!sample_valid, "R9 no strobe", {31'd0, sample_valid}, 32'd0);
            if (i == 63 && mode == 1)
                chk(subcode_out == sc, "R7 subcode", {18'd0, subcode_out}, {18'd0, sc});
            idle(gapk % 3);
            gapk++;
        end
        if (mode != 2)
            chk((vpulses - v0) == mode, "R5 strobes per frame", vpulses - v0, mode);
    endtask

    function automatic logic [15:0] lval(input int k);
        return (k == 0) ? 16'h0000 : 16'(k * 40503 + 17);
    endfunction

    function automatic logic [15:0] rval(input int k);
        return (k == 0) ? 16'hFFFF : 16'(k * 9973 + 3) ^ 16'hA5C3;
    endfunction

    function automatic logic [13:0] sval(input int k);
        return 14'(k * 2731 + 5);
    endfunction

    initial begin
        #1_500_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int v0;
        // R1 reset state
        do_reset();
        chk(!locked, "R1 locked", {31'd0, locked}, 32'd0);
        chk(!sample_valid, "R1 valid", {31'd0, sample_valid}, 32'd0);
        chk(left_out == 16'd0 && right_out == 16'd0, "R1 samples", {left_out, right_out}, 32'd0);
        chk(!left_perr && !right_perr, "R1 flags", {30'd0, left_perr, right_perr}, 32'd0);
        chk(subcode_out == 14'd0, "R1 subcode", {18'd0, subcode_out}, 32'd0);

        // R2 acquisition at every bit offset
        for (int off = 0; off < 64; off++) begin
            do_reset();
            for (int p = 0; p < off; p++) begin
                send_bit(1'b0);
                idle(p % 2);
            end
            send_frame(SYNC_OK, lval(off) & 16'h3F3F, rval(off) & 16'h3F3F,
                       sval(off) & 14'h0F3F, 1'b0, 1'b0, 0, 0, 64);
            send_frame(SYNC_OK, lval(off + 1), rval(off + 1), sval(off + 1),
                       off[0], off[1], 1, 1, 64);
        end

        // R4 R6 R7 payload sweep while locked, all parity flip pairs
        for (int k = 0; k < 24; k++)
            send_frame(SYNC_OK, lval(k), rval(k), sval(k), k[0], k[1], 1, 1, 64);

        // R10 idle with toggling data changes nothing
        v0 = vpulses;
        idle(40);
        chk(locked, "R10 lock kept in idle", {31'd0, locked}, 32'd1);
        chk(vpulses == v0, "R10 no strobe in idle", vpulses - v0, 32'd0);
        send_frame(SYNC_OK, 16'h8001, 16'h7FFE, 14'h2AAA, 1'b0, 1'b1, 1, 1, 64);

        // R8 miss tolerance and counter clearing
        send_frame(SYNC_BAD, lval(3), rval(3), sval(3), 1'b0, 1'b0, 1, 1, 64);
        send_frame(SYNC_OK, lval(4), rval(4), sval(4), 1'b1, 1'b0, 1, 1, 64);
        send_frame(SYNC_BAD, lval(5), rval(5), sval(5), 1'b0, 1'b1, 1, 1, 64);
        send_frame(SYNC_OK, lval(6), rval(6), sval(6), 1'b0, 1'b0, 1, 1, 64);
        send_frame(SYNC_BAD, lval(7), rval(7), sval(7), 1'b1, 1'b1, 1, 1, 64);
        send_frame(SYNC_BAD, lval(8) & 16'h3F3F, rval(8) & 16'h3F3F, sval(8) & 14'h0F3F,
                   1'b0, 1'b0, 0, 0, 64);
        send_frame(SYNC_OK, 16'h0102, 16'h0304, 14'h0005, 1'b0, 1'b0, 0, 0, 64);
        send_frame(SYNC_OK, lval(9), rval(9), sval(9), 1'b0, 1'b0, 1, 1, 64);

        // R3 second word missing during verify
        do_reset();
        send_frame(SYNC_OK, 16'h0A0B, 16'h0C0D, 14'h0011, 1'b0, 1'b0, 0, 0, 64);
        send_frame(SYNC_BAD, 16'h1111, 16'h2222, 14'h0333, 1'b0, 1'b0, 0, 0, 64);
        send_frame(SYNC_OK, 16'h0404, 16'h0505, 14'h0006, 1'b0, 1'b0, 0, 0, 64);
        send_frame(SYNC_OK, lval(10), rval(10), sval(10), 1'b1, 1'b0, 1, 1, 64);

        // R8 one-bit slip: lose lock after two frames, then reacquire
        send_frame(SYNC_OK, lval(11), rval(11), sval(11), 1'b0, 1'b0, 1, 1, 63);
        send_frame(SYNC_OK, 16'h0123, 16'h0321, 14'h0012, 1'b0, 1'b0, 2, 1, 64);
        send_frame(SYNC_OK, 16'h0231, 16'h0132, 14'h0021, 1'b0, 1'b0, 0, 1, 64);
        chk(!locked, "R8 lock lost after slip", {31'd0, locked}, 32'd0);
        send_frame(SYNC_OK, 16'h0303, 16'h3030, 14'h0101, 1'b0, 1'b0, 0, 0, 64);
        send_frame(SYNC_OK, lval(12), rval(12), sval(12), 1'b0, 1'b1, 1, 1, 64);

        // R1 reset while locked
        do_reset();
        chk(!locked, "R1 reset clears lock", {31'd0, locked}, 32'd0);
        chk(left_out == 16'd0, "R1 reset clears left", {16'd0, left_out}, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule